// File: doc/BRIEF.md
# Single-Carrier Reference Folding Modulator

This block makes the raw pulse-width pulse for one phase leg of a multilevel flying-capacitor converter with `N_LEVELS` output levels. It does not compare the reference against `N_LEVELS-1` stacked carriers. It finds which of the `N_LEVELS-1` equal sub-ranges (bands) of the reference span holds the sample. It then folds the sample into that band's local coordinate, from 0 at the bottom of the band to 1 at the top, and compares the result against one triangular carrier. The carrier is generated inside the block.

The carrier is an up/down counter that runs between zero and a programmable peak. At each peak and valley the block pulses a turn strobe and samples the reference. The band and the folded level therefore stay fixed for a whole half period. Downstream logic uses the band, the raw pulse, the strobe and the slope bit to route the pulse to the individual cells.

Top module: `sc_fold_modulator`

## Requirements
- R1: While `rst` is high at a rising edge, the block takes this state: `carrier_o` = 0, `rising_o` = 1, `turn_o` = 1, `pwm_o` = 0, and `band_o` = floor((N_LEVELS-1)/2)+1, which is 3 for five levels.
- R2: For an effective peak P, `carrier_o` moves by exactly one count per clock and traces 0,1,…,P,P-1,…,1,0,1,… `rising_o` is 1 in every cycle whose next step is upward.
- R3: `turn_o` is 1 exactly in the cycles where the carrier sits at 0 or at P. Equivalently, it is 1 exactly in the cycles where `rising_o` differs from its value in the previous cycle.
- R4: `ref_i` is signed two's complement with `REF_FRAC` fractional bits, so 1.0 = 16384 by default. For a clamped reference v, the band is floor((v+1)(N_LEVELS-1)/2)+1, limited to the range 1…N_LEVELS-1. Band 1 is the lowest, and v = +1 gives band N_LEVELS-1.
- R5: A `ref_i` value above +1.0 is treated as +1.0, and a value below -1.0 is treated as -1.0.
- R6: The reference is shifted by (N_LEVELS-2b+1)/(N_LEVELS-1) and scaled by (N_LEVELS-1)/2, which gives r in [0,1]. The compare level is floor(r·P), computed exactly on the fixed-point value. For five levels, r = 2v+3-b.
- R7: `pwm_o` is 1 exactly when the compare level that applies in that cycle is strictly greater than the `carrier_o` value shown in the same cycle.
- R8: The reference is sampled only in a cycle with `turn_o` = 1. The new band and level take effect from the next cycle until the next turn cycle, inclusive. Changes to `ref_i` in any other cycle have no effect on `band_o` or `pwm_o`.
- R9: A `peak_i` of 0 is treated as a peak of 1, so the carrier alternates 0,1,0,1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_i | input | REF_W | Signed fixed-point reference sample |
| peak_i | input | CNT_W | Carrier peak count |
| band_o | output | $clog2(N_LEVELS) | Band index of the sampled reference, 1 = lowest |
| pwm_o | output | 1 | Raw pulse from the folded-reference comparison |
| turn_o | output | 1 | Carrier at a peak or a valley |
| rising_o | output | 1 | 1 while the next carrier step is upward |
| carrier_o | output | CNT_W | Present carrier count |

## Verification
The carrier, slope bit and turn strobe change at every rising edge, and each value describes the count shown in that same cycle. A reference present during a turn cycle reaches `band_o` one edge later. `pwm_o` is registered against the next carrier count, so it always lines up with the `carrier_o` value of its own cycle. The bench steps a cycle-accurate arithmetic model on each rising edge and compares all outputs on the following falling edge. The stimulus deliberately changes `ref_i` every cycle, so a design that sampled at the wrong time would show a mismatch within one half period.

// File: rtl/scfm_pkg.sv
package scfm_pkg;

    typedef enum logic {
        SLOPE_FALL = 1'b0,
        SLOPE_RISE = 1'b1
    } slope_e;

endpackage

// File: rtl/scfm_carrier.sv
module scfm_carrier
    import scfm_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] peak_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_next_o,
    output logic             rising_o,
    output logic             turn_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        slope_e           dir;
        logic             turn;
    } car_t;

    car_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.dir == SLOPE_RISE) begin
            if (st_q.cnt >= peak_i) begin
                // peak lowered below the count: head back down at once
                st_d.cnt = st_q.cnt - CNT_W'(1);
                st_d.dir = (st_d.cnt == '0) ? SLOPE_RISE : SLOPE_FALL;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
                st_d.dir = (st_d.cnt < peak_i) ? SLOPE_RISE : SLOPE_FALL;
            end
        end else begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
            st_d.dir = (st_d.cnt == '0) ? SLOPE_RISE : SLOPE_FALL;
        end
        st_d.turn = (st_d.dir != st_q.dir);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{cnt: '0, dir: SLOPE_RISE, turn: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o      = st_q.cnt;
    assign cnt_next_o = st_d.cnt;
    assign rising_o   = (st_q.dir == SLOPE_RISE);
    assign turn_o     = st_q.turn;

endmodule

// File: rtl/scfm_fold.sv
module scfm_fold #(
    parameter int N_LEVELS = 5,
    parameter int REF_W    = 16,
    parameter int REF_FRAC = 14,
    parameter int CNT_W    = 10
) (
    input  logic signed [REF_W-1:0]            ref_i,
    input  logic        [CNT_W-1:0]            peak_i,
    output logic        [$clog2(N_LEVELS)-1:0] band_o,
    output logic        [CNT_W-1:0]            level_o
);

    localparam int BAND_W = $clog2(N_LEVELS);
    localparam int M_W    = $clog2(N_LEVELS);
    localparam int U_W    = REF_FRAC + 2;
    localparam int W_W    = U_W + M_W;
    localparam int B_W    = M_W + 1;
    localparam int P_W    = U_W + CNT_W;
    localparam logic signed [REF_W-1:0] POS1 = REF_W'(1 << REF_FRAC);
    localparam logic signed [REF_W-1:0] NEG1 = -POS1;
    localparam logic [B_W-1:0] BM1_MAX = B_W'(N_LEVELS - 2);

    logic signed [REF_W-1:0] v_clamp;
    logic [U_W-1:0]          u_pos;
    logic [W_W-1:0]          w_span;
    logic [B_W-1:0]          bm1_raw;
    logic [B_W-1:0]          bm1;
    logic [U_W-1:0]          resid;
    logic [P_W-1:0]          prod;

    always_comb begin
        if (ref_i > POS1) begin
            v_clamp = POS1;
        end else if (ref_i < NEG1) begin
            v_clamp = NEG1;
        end else begin
            v_clamp = ref_i;
        end
        // distance above -1.0, in [0, 2.0]
        u_pos   = U_W'(v_clamp) + U_W'(POS1);
        // scaled by (levels-1): units of 2^-(REF_FRAC+1), i.e. in band widths
        w_span  = W_W'(u_pos) * W_W'(N_LEVELS - 1);
        bm1_raw = B_W'(w_span >> (REF_FRAC + 1));
        bm1     = (bm1_raw > BM1_MAX) ? BM1_MAX : bm1_raw;
        // position inside the band, 0..1 in Q(REF_FRAC+1)
        resid   = U_W'(w_span - (W_W'(bm1) << (REF_FRAC + 1)));
        prod    = P_W'(resid) * P_W'(peak_i);
        level_o = CNT_W'(prod >> (REF_FRAC + 1));
        band_o  = BAND_W'(bm1) + BAND_W'(1);
    end

endmodule

// File: rtl/sc_fold_modulator.sv
module sc_fold_modulator #(
    parameter int N_LEVELS = 5,
    parameter int REF_W    = 16,
    parameter int REF_FRAC = 14,
    parameter int CNT_W    = 10
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic signed [REF_W-1:0]           ref_i,
    input  logic        [CNT_W-1:0]           peak_i,
    output logic        [$clog2(N_LEVELS)-1:0] band_o,
    output logic                              pwm_o,
    output logic                              turn_o,
    output logic                              rising_o,
    output logic        [CNT_W-1:0]           carrier_o
);

    localparam int BAND_W = $clog2(N_LEVELS);
    localparam logic [BAND_W-1:0] RESET_BAND = BAND_W'((N_LEVELS - 1) / 2 + 1);

    typedef struct packed {
        logic [BAND_W-1:0] band;
        logic [CNT_W-1:0]  level;
        logic              pwm;
    } mod_t;

    mod_t m_d, m_q;

    logic [CNT_W-1:0]  peak_eff;
    logic [CNT_W-1:0]  cnt_now;
    logic [CNT_W-1:0]  cnt_next;
    logic              turn_now;
    logic              rising_now;
    logic [BAND_W-1:0] fold_band;
    logic [CNT_W-1:0]  fold_level;
    logic [CNT_W-1:0]  level_sel;

    assign peak_eff = (peak_i == '0) ? CNT_W'(1) : peak_i;

    scfm_carrier #(
        .CNT_W(CNT_W)
    ) u_carrier (
        .clk       (clk),
        .rst       (rst),
        .peak_i    (peak_eff),
        .cnt_o     (cnt_now),
        .cnt_next_o(cnt_next),
        .rising_o  (rising_now),
        .turn_o    (turn_now)
    );

    scfm_fold #(
        .N_LEVELS(N_LEVELS),
        .REF_W   (REF_W),
        .REF_FRAC(REF_FRAC),
        .CNT_W   (CNT_W)
    ) u_fold (
        .ref_i  (ref_i),
        .peak_i (peak_eff),
        .band_o (fold_band),
        .level_o(fold_level)
    );

    always_comb begin
        m_d       = m_q;
        level_sel = turn_now ? fold_level : m_q.level;
        if (turn_now) begin
            m_d.band  = fold_band;
            m_d.level = fold_level;
        end
        // registered against the next count so pwm lines up with carrier_o
        m_d.pwm = (level_sel > cnt_next);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            m_q <= '{band: RESET_BAND, level: '0, pwm: 1'b0};
        end else begin
            m_q <= m_d;
        end
    end

    assign band_o    = m_q.band;
    assign pwm_o     = m_q.pwm;
    assign turn_o    = turn_now;
    assign rising_o  = rising_now;
    assign carrier_o = cnt_now;

endmodule

// File: rtl/scfm_checker.sv
module scfm_checker #(
    parameter int N_LEVELS = 5,
    parameter int CNT_W    = 10
) (
    input logic                        clk,
    input logic                        rst,
    input logic [$clog2(N_LEVELS)-1:0] band_o,
    input logic                        pwm_o,
    input logic                        turn_o,
    input logic                        rising_o,
    input logic [CNT_W-1:0]            carrier_o
);

    localparam int BAND_W = $clog2(N_LEVELS);
    localparam logic [BAND_W-1:0] B_MIN = BAND_W'(1);
    localparam logic [BAND_W-1:0] B_MAX = BAND_W'(N_LEVELS - 1);

    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
        end else begin
            seen_q <= 1'b1;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (carrier_o == '0 && rising_o && turn_o && !pwm_o));

    assert_unit_step_R2: assert property (@(posedge clk) disable iff (rst)
        seen_q |-> (({1'b0, carrier_o} == {1'b0, $past(carrier_o)} + 1'b1) ||
                    ({1'b0, carrier_o} + 1'b1 == {1'b0, $past(carrier_o)})));

    assert_turn_on_flip_R3: assert property (@(posedge clk) disable iff (rst)
        seen_q |-> (turn_o == (rising_o != $past(rising_o))));

    assert_band_range_R4: assert property (@(posedge clk) disable iff (rst)
        (band_o >= B_MIN) && (band_o <= B_MAX));

    assert_band_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (seen_q && !$past(turn_o)) |-> $stable(band_o));

endmodule

bind sc_fold_modulator scfm_checker #(
    .N_LEVELS(N_LEVELS),
    .CNT_W   (CNT_W)
) u_scfm_checker (
    .clk      (clk),
    .rst      (rst),
    .band_o   (band_o),
    .pwm_o    (pwm_o),
    .turn_o   (turn_o),
    .rising_o (rising_o),
    .carrier_o(carrier_o)
);

// File: tb/sc_fold_modulator_bench.sv
`timescale 1ns/1ps
module sc_fold_modulator_bench;

    localparam int N     = 5;
    localparam int RW    = 16;
    localparam int FR    = 14;
    localparam int CW    = 10;
    localparam int BW    = $clog2(N);
    localparam int ONE   = 1 << FR;
    localparam int WATCH = 150000;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic signed [RW-1:0] ref_i = '0;
    logic [CW-1:0]        peak_i = CW'(8);
    logic [BW-1:0]        band_o;
    logic                 pwm_o;
    logic                 turn_o;
    logic                 rising_o;
    logic [CW-1:0]        carrier_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit mon_en = 1'b0;
    bit done   = 1'b0;
    string tag_car  = "R2";
    string tag_band = "R4";
    string tag_pwm  = "R7";

    // model state
    int m_cnt, m_dir, m_stb, m_band, m_lev, m_pwm;

    always #2.5 clk = ~clk;

    sc_fold_modulator #(
        .N_LEVELS(N), .REF_W(RW), .REF_FRAC(FR), .CNT_W(CW)
    ) u_sc_fold_modulator (
        .clk(clk), .rst(rst), .ref_i(ref_i), .peak_i(peak_i),
        .band_o(band_o), .pwm_o(pwm_o), .turn_o(turn_o),
        .rising_o(rising_o), .carrier_o(carrier_o)
    );

    function automatic int clampv(int v);
        if (v > ONE) return ONE;
        if (v < -ONE) return -ONE;
        return v;
    endfunction

    function automatic int bm1_of(int v);
        int w = (clampv(v) + ONE) * (N - 1);
        int b = w / (2 * ONE);
        if (b > N - 2) b = N - 2;
        return b;
    endfunction

    function automatic int band_of(int v);
        return bm1_of(v) + 1;
    endfunction

    function automatic int lev_of(int v, int p);
        int w = (clampv(v) + ONE) * (N - 1);
        int r = w - bm1_of(v) * 2 * ONE;
        return (r * p) / (2 * ONE);
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // triangle carrier and sample-at-turn model
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_cnt = 0; m_dir = 1; m_stb = 1; m_pwm = 0; m_lev = 0;
            m_band = band_of(0);
        end else begin
            int pe, lsel, nc, nd;
            pe = (int'(peak_i) < 1) ? 1 : int'(peak_i);
            lsel = m_stb ? lev_of(int'(ref_i), pe) : m_lev;
            if (m_stb) begin
                m_band = band_of(int'(ref_i));
                m_lev  = lsel;
            end
            if (m_dir == 1) begin
                if (m_cnt >= pe) begin nc = m_cnt - 1; nd = (nc == 0) ? 1 : 0; end
                else begin nc = m_cnt + 1; nd = (nc < pe) ? 1 : 0; end
            end else begin
                nc = m_cnt - 1; nd = (nc == 0) ? 1 : 0;
            end
            m_stb = (nd != m_dir) ? 1 : 0;
            m_pwm = (lsel > nc) ? 1 : 0;
            m_cnt = nc;
            m_dir = nd;
        end
    end

    always @(negedge clk) begin
        if (mon_en && !done) begin
            chk({tag_car, " carrier"}, int'(carrier_o), m_cnt);
            chk({tag_car, " rising"}, int'(rising_o), m_dir);
            chk("R3 turn", int'(turn_o), m_stb);
            chk({tag_band, " band"}, int'(band_o), m_band);
            chk({tag_pwm, " pwm"}, int'(pwm_o), m_pwm);
        end
    end

    always @(posedge clk) begin
        if (cyc > WATCH && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected < %0d cycles", cyc, WATCH);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic restart(int p);
        @(negedge clk);
        rst = 1'b1;
        peak_i = CW'(p);
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        int highs;
        repeat (2) @(negedge clk);
        // R1: reset state seen at the ports
        chk("R1 carrier", int'(carrier_o), 0);
        chk("R1 rising", int'(rising_o), 1);
        chk("R1 turn", int'(turn_o), 1);
        chk("R1 pwm", int'(pwm_o), 0);
        chk("R1 band", int'(band_o), 3);
        mon_en = 1'b1;
        rst = 1'b0;

        // R5 R8: sweep past both ends, ref changes every cycle
        tag_band = "R4 R5 R8"; tag_pwm = "R6 R7 R8";
        for (int v = -18000; v <= 18000; v += 37) begin
            @(negedge clk);
            ref_i = RW'(v);
        end

        // R6 R7: odd peak, dense in-range sweep
        restart(13);
        tag_band = "R4 R8"; tag_pwm = "R6 R7";
        for (int v = -16500; v <= 16500; v += 11) begin
            @(negedge clk);
            ref_i = RW'(v);
        end

        // R4: band edges held for whole periods
        restart(8);
        tag_band = "R4"; tag_pwm = "R6";
        for (int k = 0; k < 13; k++) begin
            int edges[13] = '{-16384, -16383, -8193, -8192, -8191, -1, 0,
                              1, 8191, 8192, 8193, 16383, 16384};
            @(negedge clk);
            ref_i = RW'(edges[k]);
            repeat (17) @(negedge clk);
        end

        // R6: v = 0.25 with P = 8 -> band 3, level 4, 7 high cycles per period
        @(negedge clk);
        ref_i = RW'(4096);
        repeat (40) @(negedge clk);
        chk("R4 band at 0.25", int'(band_o), 3);
        highs = 0;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            highs += int'(pwm_o);
        end
        chk("R6 pulse count per period", highs, 7);

        // R9: zero peak behaves as one
        restart(0);
        tag_car = "R2 R9";
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            ref_i = RW'((k * 1531) % 32768 - 16384);
        end

        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule